// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Software End-of-Interrupt

This block gathers up to eight device interrupt requests onto a single processor interrupt line. It records a rising edge on each request input in a per-input pending bit. A programmable mask then hides chosen inputs from arbitration. Among the unmasked pending requests, the input with the lowest index wins.

When the processor acknowledges with a one-cycle strobe, the controller puts the winner's interrupt type on an 8-bit vector bus for that cycle, together with a valid flag. The type is the vector base plus the input index. In the same cycle the controller moves the winner from pending to in-service.

While a routine is in service, requests of equal or lower priority stay latched and do not reach the interrupt line. This holds until software writes the end-of-interrupt code to the command port, which retires the highest-priority in-service entry. A request of higher priority than everything in service raises the line again, so routines can nest.

Software reaches the block through a small port interface. The mask port can be written and read back. The command port is write-only.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, a read of port 0x21 returns 0xFF (all inputs masked), and no request is pending or in service.
- R2: A request is latched only on a rising edge of its input. An input held high after its acknowledge does not request again until it falls and rises.
- R3: Writing port 0x21 sets the mask, and reading port 0x21 returns it. A mask bit of 1 keeps that input out of arbitration but keeps its pending bit, so clearing the mask bit later raises the interrupt line.
- R4: Among unmasked pending inputs, index 0 has the highest priority and index 7 the lowest. The type delivered for input i is 0x08 + i.
- R5: An acknowledge strobe while the interrupt line is high gives vector-valid in that same cycle, with the winner's type. It clears the winner's pending bit and marks the winner in service.
- R6: A request of equal or lower priority than the highest in-service entry keeps the interrupt line low until an end-of-interrupt retires that entry.
- R7: A request of higher priority than every in-service entry raises the interrupt line, and its acknowledge delivers its own type while the earlier routine remains in service.
- R8: Writing 0x20 to port 0x20 retires only the highest-priority in-service entry. Any other value written to port 0x20 has no effect.
- R9: An acknowledge strobe while the interrupt line is low gives no vector-valid, and it changes neither the pending nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Device request inputs, index 0 has the highest priority |
| intr_out | output | 1 | Interrupt request to the processor |
| inta_in | input | 1 | Single-cycle acknowledge strobe |
| vec_valid | output | 1 | Vector bus carries a type in this cycle |
| vec_data | output | 8 | Interrupt type of the acknowledged input |
| io_addr | input | 8 | Port address |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data (mask port only, else zero) |

## Verification
A request edge applied before a clock edge is latched at that edge, and the interrupt line reflects it right after that edge. The bench therefore drives stimulus just after a falling edge and checks the line at the next falling edge. The vector and its valid flag are combinational on the acknowledge strobe, so they are sampled a short delay after the strobe is driven and before the rising edge. The effects of an acknowledge, an end-of-interrupt or a mask write on the interrupt line show up one rising edge later, and they are sampled there. The bench sweeps every request pattern and every mask value, and it computes the expected winner with its own lowest-set-bit function.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [1:0] {
      IO_IDLE    = 2'd0,
      IO_MASK_WR = 2'd1,
      IO_EOI     = 2'd2,
      IO_CMD_NOP = 2'd3
   } io_op_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = vec[i] & ~seen[i];
      assign seen[i+1] = seen[i] | vec[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   always_comb begin
      p_grant_onehot_r4: assert ($onehot0(grant) && (any == (grant != '0)))
         else $error("picker grant not one-hot or inconsistent");
   end
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   logic [N-1:0] irq_q;
   logic [N-1:0] rise;

   assign rise = irq_in & ~irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= '0;
         pend  <= '0;
      end else begin
         irq_q <= irq_in;
         pend  <= (pend & ~clr) | rise;
      end
   end

   p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0) |=> ((pend & $past(clr & ~rise)) == '0))
      else $error("acknowledged request still pending");

   p_level_no_retrigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise == '0 && clr == '0) |=> (pend == $past(pend)))
      else $error("pending changed without edge or acknowledge");
endmodule

// File: rtl/prio_irq_isr.sv
module prio_irq_isr #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_oh,
   input  logic          eoi,
   output logic [N-1:0]  isr,
   output logic [IW-1:0] top_idx,
   output logic          busy
);
   logic [N-1:0] top_oh;

   prio_irq_pick #(.N(N)) u_top (
      .vec   (isr),
      .grant (top_oh),
      .idx   (top_idx),
      .any   (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~(eoi ? top_oh : '0)) | set_oh;
   end

   p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && busy && set_oh == '0) |=> ($countones(isr) + 1 == $countones($past(isr))))
      else $error("end-of-interrupt did not retire exactly one entry");

   p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_oh != '0) |=> ((isr & $past(set_oh)) == $past(set_oh)))
      else $error("acknowledged input not in service");
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int          NUM_IRQ   = 8,
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 8,
   parameter logic [7:0]  MASK_ADDR = 8'h21,
   parameter logic [7:0]  CMD_ADDR  = 8'h20,
   parameter logic [7:0]  EOI_CODE  = 8'h20,
   parameter logic [7:0]  VEC_BASE  = 8'h08
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   output logic               intr_out,
   input  logic               inta_in,
   output logic               vec_valid,
   output logic [DATA_W-1:0]  vec_data,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [DATA_W-1:0]  io_wdata,
   output logic [DATA_W-1:0]  io_rdata
);
   import prio_irq_pkg::*;

   localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if (NUM_IRQ < 2 || NUM_IRQ > DATA_W) begin : g_bad_count
      $error("NUM_IRQ must lie between 2 and DATA_W");
   end
   if (ADDR_W < 8 || DATA_W < 8) begin : g_bad_width
      $error("port address and data must be at least 8 bits");
   end

   logic [NUM_IRQ-1:0] mask_q;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] elig;
   logic [NUM_IRQ-1:0] win_oh;
   logic [NUM_IRQ-1:0] ack_oh;
   logic [NUM_IRQ-1:0] isr;
   logic [IW-1:0]      win_idx;
   logic [IW-1:0]      top_idx;
   logic               elig_any;
   logic               busy;
   logic               ack;
   io_op_e             io_op;

   always_comb begin
      io_op = IO_IDLE;
      if (io_wr && io_addr == ADDR_W'(MASK_ADDR))
         io_op = IO_MASK_WR;
      else if (io_wr && io_addr == ADDR_W'(CMD_ADDR))
         io_op = (io_wdata == DATA_W'(EOI_CODE)) ? IO_EOI : IO_CMD_NOP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  mask_q <= '1;
      else if (io_op == IO_MASK_WR) mask_q <= io_wdata[NUM_IRQ-1:0];
   end

   assign io_rdata = (io_rd && io_addr == ADDR_W'(MASK_ADDR)) ? DATA_W'(mask_q) : '0;

   prio_irq_pend #(.N(NUM_IRQ)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .clr    (ack_oh),
      .pend   (pend)
   );

   assign elig = pend & ~mask_q;

   prio_irq_pick #(.N(NUM_IRQ)) u_win (
      .vec   (elig),
      .grant (win_oh),
      .idx   (win_idx),
      .any   (elig_any)
   );

   prio_irq_isr #(.N(NUM_IRQ)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_oh  (ack_oh),
      .eoi     (io_op == IO_EOI),
      .isr     (isr),
      .top_idx (top_idx),
      .busy    (busy)
   );

   assign intr_out  = elig_any && (!busy || win_idx < top_idx);
   assign ack       = inta_in && intr_out;
   assign ack_oh    = ack ? win_oh : '0;
   assign vec_valid = ack;
   assign vec_data  = ack ? (DATA_W'(VEC_BASE) + DATA_W'(win_idx)) : '0;

   p_intr_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      intr_out |-> ((pend & ~mask_q) != '0))
      else $error("interrupt raised with nothing eligible");

   p_spurious_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_in && !intr_out && io_op != IO_EOI) |=> (isr == $past(isr)))
      else $error("spurious acknowledge changed in-service state");

   p_nop_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_op == IO_CMD_NOP && !ack) |=> (isr == $past(isr)))
      else $error("non-EOI command changed in-service state");
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       intr_out;
   logic       inta_in = 1'b0;
   logic       vec_valid;
   logic [7:0] vec_data;
   logic [7:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .intr_out(intr_out),
      .inta_in(inta_in), .vec_valid(vec_valid), .vec_data(vec_data),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata)
   );

   function automatic int lowest(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse(input logic [7:0] v);
      irq_in = v; step(); irq_in = '0; step();
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1; step(); io_wr = 1'b0;
   endtask

   task automatic mask_read(input string req, input logic [7:0] exp);
      io_addr = 8'h21; io_rd = 1'b1; #1;
      check(req, io_rdata, exp);
      io_rd = 1'b0;
   endtask

   task automatic ack(input string req, input logic exp_v, input logic [7:0] exp_d);
      inta_in = 1'b1; #1;
      check(req, vec_valid, exp_v);
      if (exp_v) check(req, vec_data, exp_d);
      step(); inta_in = 1'b0;
   endtask

   task automatic eoi();
      io_write(8'h20, 8'h20);
   endtask

   task automatic drain();
      io_write(8'h21, 8'h00);
      for (int k = 0; k < 9; k++) begin
         if (intr_out) begin inta_in = 1'b1; step(); inta_in = 1'b0; end
         eoi();
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] p;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 intr", intr_out, 0);
      mask_read("R1 mask", 8'hFF);
      io_write(8'h21, 8'h00);
      check("R1 nothing pending", intr_out, 0);

      // R4 R5 R6 priority sweep over all request patterns
      for (int pat = 1; pat < 256; pat++) begin
         p = 8'(pat);
         pulse(p);
         while (p != 0) begin
            check("R4 intr", intr_out, 1);
            ack("R5 vec", 1'b1, 8'h08 + 8'(lowest(p)));
            p[lowest(p)] = 1'b0;
            check("R6 holdoff", intr_out, 0);
            eoi();
         end
         check("R5 drained", intr_out, 0);
      end

      // R3 mask sweep
      for (int m = 0; m < 256; m++) begin
         io_write(8'h21, 8'(m));
         mask_read("R3 readback", 8'(m));
         pulse(8'hFF);
         check("R3 intr", intr_out, (m != 255));
         if (m != 255) begin
            ack("R3 winner", 1'b1, 8'h08 + 8'(lowest(~8'(m))));
            eoi();
         end
         drain();
      end

      // R3 masked request kept pending
      io_write(8'h21, 8'h10);
      pulse(8'h10);
      check("R3 masked", intr_out, 0);
      // R9 spurious acknowledge
      ack("R9 no valid", 1'b0, 8'h00);
      io_write(8'h21, 8'h00);
      check("R3 unmask raises", intr_out, 1);
      ack("R9 pending kept", 1'b1, 8'h0C);
      eoi();

      // R7 nesting and R8 EOI ordering
      pulse(8'h20);
      ack("R7 first", 1'b1, 8'h0D);
      pulse(8'h04);
      check("R7 preempt", intr_out, 1);
      ack("R7 nested", 1'b1, 8'h0A);
      pulse(8'h08);
      check("R6 lower held", intr_out, 0);
      io_write(8'h20, 8'h21);
      check("R8 non-eoi ignored", intr_out, 0);
      io_write(8'h20, 8'h00);
      check("R8 zero ignored", intr_out, 0);
      eoi();
      check("R8 top retired", intr_out, 1);
      ack("R8 next", 1'b1, 8'h0B);
      eoi();
      check("R8 idx5 still in service", intr_out, 0);
      pulse(8'h40);
      check("R6 below idx5", intr_out, 0);
      eoi();
      check("R8 idx5 retired", intr_out, 1);
      ack("R8 idx6", 1'b1, 8'h0E);
      eoi();

      // R2 level held high
      irq_in = 8'h02; step();
      check("R2 edge", intr_out, 1);
      ack("R2 vec", 1'b1, 8'h09);
      eoi(); step();
      check("R2 no retrigger", intr_out, 0);
      irq_in = 8'h00; step();
      irq_in = 8'h02; step();
      check("R2 new edge", intr_out, 1);
      ack("R2 vec2", 1'b1, 8'h09);
      eoi();
      irq_in = 8'h00; step();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule